// File: doc/BRIEF.md
# Spike-Timing Plasticity Weight Updater

This block holds the weight of a single digital synapse and adjusts it from the relative timing of presynaptic and postsynaptic spikes. Each spike is a one-cycle pulse. A separate one-cycle enable, `tick`, marks each millisecond of model time. Two age timers count the ticks that have passed since the last spike on each side.

When a postsynaptic spike arrives shortly after a presynaptic one, the weight grows by a proportional step. When a presynaptic spike arrives shortly after a postsynaptic one, the weight shrinks by the same kind of step. Pairings outside the window cause no change. So does exact coincidence.

Each accepted pairing goes through a three-state sequence:
- `ST_IDLE` waits for a spike whose partner age lies inside the window. This is the accept transition.
- `ST_STEP` computes the saturated candidate weight, then always advances.
- `ST_COMMIT` writes the candidate to the weight register, then always returns to `ST_IDLE`.

The weight is bounded by the `w_floor` and `w_ceil` inputs, which are normally set more than ten to one apart.

Top module: `stdp_weight_unit`

## Requirements
- R1: After reset the weight equals W_RESET (1024) and both age timers are saturated, so a first spike on either side changes nothing.
- R2: A postsynaptic pulse accepted in `ST_IDLE` while the presynaptic age is 1 to 80 ticks raises the weight. The increase is step = max(weight >> 6, 1), limited to `w_ceil`.
- R3: A presynaptic pulse accepted in `ST_IDLE` while the postsynaptic age is 1 to 80 ticks lowers the weight by step = max(weight >> 6, 1), limited to `w_floor`.
- R4: A partner age of 0 ticks, or of 81 ticks and above (including the tail beyond 100), leaves the weight unchanged.
- R5: Presynaptic and postsynaptic pulses in the same cycle make no update, and both age timers restart from 0.
- R6: Each age timer advances by one only on a cycle with `tick` high. It saturates at 127 without wrapping and returns to 0 on its own spike, even when `tick` is high in the same cycle.
- R7: The weight never leaves the range [`w_floor`, `w_ceil`]; repeated steps hold it at the bound.
- R8: An accepted pulse sampled at clock edge E leaves the weight unchanged through edge E+1. The new weight appears after edge E+2 (`ST_IDLE` to `ST_STEP` to `ST_COMMIT`), and the weight changes at no other time.
- R9: When weight >> 6 is zero (weight below 64), the step is one LSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle millisecond enable for the age timers |
| pre_spike | input | 1 | Presynaptic spike pulse |
| post_spike | input | 1 | Postsynaptic spike pulse |
| w_floor | input | 12 | Lowest allowed weight |
| w_ceil | input | 12 | Highest allowed weight |
| weight | output | 12 | Current synaptic weight |

## Verification
The bound check assumes three things about the inputs:
- `w_floor` and `w_ceil` stay constant outside reset.
- `w_floor` ≤ W_RESET ≤ `w_ceil`.
- Spike pulses are spaced far enough apart that each pulse is sampled in `ST_IDLE`.

The stimulus changes the bounds only while reset is asserted and picks them around the reset weight. It waits several cycles after every pulse before sending the next one. Before each pairing it lets more than a hundred ticks pass, so that ages left over from the previous scenario cannot produce a stray pairing.

// File: rtl/stdp_pkg.sv
package stdp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_STEP   = 2'd1,
        ST_COMMIT = 2'd2
    } upd_state_t;

    typedef enum logic [1:0] {
        ADJ_NONE = 2'd0,
        ADJ_UP   = 2'd1,
        ADJ_DOWN = 2'd2
    } adj_kind_t;
endpackage

// File: rtl/spike_age_timer.sv
module spike_age_timer #(
    parameter int AGE_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             spike,
    output logic [AGE_W-1:0] age
);
    localparam logic [AGE_W-1:0] AGE_MAX = {AGE_W{1'b1}};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age <= AGE_MAX;
        end else if (spike) begin
            age <= '0;
        end else if (tick && (age != AGE_MAX)) begin
            age <= age + 1'b1;
        end
    end

    // R6
    age_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!spike && !tick) |=> $stable(age));

    // R6
    age_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!spike && age == AGE_MAX) |=> age == AGE_MAX);
endmodule

// File: rtl/stdp_pair_judge.sv
module stdp_pair_judge
    import stdp_pkg::*;
#(
    parameter int AGE_W  = 7,
    parameter int WIN_LO = 1,
    parameter int WIN_HI = 80
) (
    input  logic             pre,
    input  logic             post,
    input  logic [AGE_W-1:0] pre_age,
    input  logic [AGE_W-1:0] post_age,
    output adj_kind_t        kind
);
    logic pre_in_win;
    logic post_in_win;

    always_comb begin
        pre_in_win  = (int'(pre_age)  >= WIN_LO) && (int'(pre_age)  <= WIN_HI);
        post_in_win = (int'(post_age) >= WIN_LO) && (int'(post_age) <= WIN_HI);
        kind = ADJ_NONE;
        if (pre && post) begin
            kind = ADJ_NONE;
        end else if (post && pre_in_win) begin
            kind = ADJ_UP;
        end else if (pre && post_in_win) begin
            kind = ADJ_DOWN;
        end
    end
endmodule

// File: rtl/stdp_step_calc.sv
module stdp_step_calc
    import stdp_pkg::*;
#(
    parameter int W_W   = 12,
    parameter int SHIFT = 6
) (
    input  adj_kind_t      kind,
    input  logic [W_W-1:0] w_cur,
    input  logic [W_W-1:0] w_lo,
    input  logic [W_W-1:0] w_hi,
    output logic [W_W-1:0] w_next
);
    logic [W_W-1:0] step;
    logic [W_W:0]   sum;
    logic [W_W:0]   low_guard;

    always_comb begin
        step = w_cur >> SHIFT;
        if (step == '0) begin
            step = {{(W_W-1){1'b0}}, 1'b1};
        end
        sum       = {1'b0, w_cur} + {1'b0, step};
        low_guard = {1'b0, w_lo} + {1'b0, step};
        w_next    = w_cur;
        unique case (kind)
            ADJ_UP: begin
                w_next = (sum > {1'b0, w_hi}) ? w_hi : sum[W_W-1:0];
            end
            ADJ_DOWN: begin
                w_next = ({1'b0, w_cur} < low_guard) ? w_lo : (w_cur - step);
            end
            default: begin
                w_next = w_cur;
            end
        endcase
    end
endmodule

// File: rtl/stdp_weight_unit.sv
module stdp_weight_unit
    import stdp_pkg::*;
#(
    parameter int             W_W        = 12,
    parameter int             AGE_W      = 7,
    parameter int             WIN_LO     = 1,
    parameter int             WIN_HI     = 80,
    parameter int             STEP_SHIFT = 6,
    parameter logic [W_W-1:0] W_RESET    = 12'd1024
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick,
    input  logic           pre_spike,
    input  logic           post_spike,
    input  logic [W_W-1:0] w_floor,
    input  logic [W_W-1:0] w_ceil,
    output logic [W_W-1:0] weight
);
    localparam int N_SIDE = 2;

    logic [N_SIDE-1:0] spk_vec;
    logic [AGE_W-1:0]  age_vec [N_SIDE];

    assign spk_vec = {post_spike, pre_spike};

    for (genvar g = 0; g < N_SIDE; g++) begin : g_age
        spike_age_timer #(.AGE_W(AGE_W)) u_timer (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (tick),
            .spike (spk_vec[g]),
            .age   (age_vec[g])
        );
    end

    adj_kind_t judge_kind;

    stdp_pair_judge #(
        .AGE_W  (AGE_W),
        .WIN_LO (WIN_LO),
        .WIN_HI (WIN_HI)
    ) u_judge (
        .pre      (pre_spike),
        .post     (post_spike),
        .pre_age  (age_vec[0]),
        .post_age (age_vec[1]),
        .kind     (judge_kind)
    );

    upd_state_t     state_q, state_d;
    adj_kind_t      adj_q;
    logic [W_W-1:0] weight_q;
    logic [W_W-1:0] cand_q;
    logic [W_W-1:0] calc_next;

    stdp_step_calc #(
        .W_W   (W_W),
        .SHIFT (STEP_SHIFT)
    ) u_calc (
        .kind   (adj_q),
        .w_cur  (weight_q),
        .w_lo   (w_floor),
        .w_hi   (w_ceil),
        .w_next (calc_next)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = (judge_kind != ADJ_NONE) ? ST_STEP : ST_IDLE;
            ST_STEP:   state_d = ST_COMMIT;
            ST_COMMIT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Datapath and output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            adj_q    <= ADJ_NONE;
            cand_q   <= W_RESET;
            weight_q <= W_RESET;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (judge_kind != ADJ_NONE) begin
                        adj_q <= judge_kind;
                    end
                end
                ST_STEP: begin
                    cand_q <= calc_next;
                end
                ST_COMMIT: begin
                    weight_q <= cand_q;
                end
                default: begin
                    adj_q <= ADJ_NONE;
                end
            endcase
        end
    end

    assign weight = weight_q;

    // R8
    step_to_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STEP) |=> (state_q == ST_COMMIT));

    // R8
    weight_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_COMMIT) |=> $stable(weight_q));

    // R7
    weight_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (weight_q >= w_floor) && (weight_q <= w_ceil));

    // R5
    coincide_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && pre_spike && post_spike) |=> (state_q == ST_IDLE));

    // R4
    far_pair_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && post_spike && !pre_spike && int'(age_vec[0]) > WIN_HI)
        |=> (state_q == ST_IDLE));

    // R2
    up_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COMMIT && adj_q == ADJ_UP) |=> (weight_q >= $past(weight_q)));

    // R3
    down_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COMMIT && adj_q == ADJ_DOWN) |=> (weight_q <= $past(weight_q)));
endmodule

// File: tb/stdp_weight_unit_test.sv
`timescale 1ns/1ps
module stdp_weight_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        pre_spike = 1'b0;
    logic        post_spike = 1'b0;
    logic [11:0] w_floor = 12'd40;
    logic [11:0] w_ceil = 12'd3000;
    logic [11:0] weight;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    int exp_w = 1024;

    always #2.5 clk = ~clk;

    stdp_weight_unit uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .pre_spike  (pre_spike),
        .post_spike (post_spike),
        .w_floor    (w_floor),
        .w_ceil     (w_ceil),
        .weight     (weight)
    );

    function automatic int step_of(int w);
        int s;
        s = w >> 6;
        return (s == 0) ? 1 : s;
    endfunction

    function automatic int model_up(int w, int c);
        return (w + step_of(w) > c) ? c : w + step_of(w);
    endfunction

    function automatic int model_down(int w, int f);
        return (w < f + step_of(w)) ? f : w - step_of(w);
    endfunction

    task automatic chk(string tag, int actual, int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, actual, expected);
        end
    endtask

    task automatic do_reset(int f, int c);
        @(negedge clk);
        rst_n = 1'b0;
        w_floor = f[11:0];
        w_ceil = c[11:0];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        exp_w = 1024;
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
        end
    endtask

    task automatic pulse(bit a, bit b);
        @(negedge clk);
        pre_spike = a;
        post_spike = b;
        @(negedge clk);
        pre_spike = 1'b0;
        post_spike = 1'b0;
    endtask

    // One pairing, checked at every latency step (R8)
    task automatic pair(bit post_first, int sep, string tag);
        int old_w;
        int new_w;
        ticks(110);
        old_w = exp_w;
        new_w = exp_w;
        if (sep >= 1 && sep <= 80) begin
            new_w = post_first ? model_down(exp_w, int'(w_floor)) : model_up(exp_w, int'(w_ceil));
        end
        pulse(!post_first, post_first);
        ticks(sep);
        pulse(post_first, !post_first);
        chk({tag, " R8 hold after E"}, int'(weight), old_w);
        @(negedge clk);
        chk({tag, " R8 hold after E+1"}, int'(weight), old_w);
        @(negedge clk);
        chk(tag, int'(weight), new_w);
        exp_w = new_w;
    endtask

    task automatic t_reset();
        do_reset(40, 3000);
        chk("R1 reset weight", int'(weight), 1024);
        pulse(1'b0, 1'b1);
        repeat (3) @(negedge clk);
        chk("R1 first post no change", int'(weight), 1024);
        pulse(1'b1, 1'b0);
        repeat (3) @(negedge clk);
        chk("R1 first pre no change", int'(weight), 1024);
    endtask

    task automatic t_windows();
        pair(1'b0, 10, "R2 sep10 up");
        pair(1'b0, 1, "R2 sep1 up");
        pair(1'b0, 80, "R2 sep80 up");
        pair(1'b1, 5, "R3 sep5 down");
        pair(1'b1, 1, "R3 sep1 down");
        pair(1'b1, 80, "R3 sep80 down");
        pair(1'b0, 0, "R4 coincide pre-first");
        pair(1'b1, 0, "R4 coincide post-first");
        pair(1'b0, 81, "R4 sep81 pre-first");
        pair(1'b1, 81, "R4 sep81 post-first");
        pair(1'b0, 100, "R4 sep100");
        pair(1'b1, 120, "R4 sep120");
    endtask

    task automatic t_same_cycle();
        int w0;
        ticks(110);
        w0 = exp_w;
        pulse(1'b1, 1'b1);
        repeat (3) @(negedge clk);
        chk("R5 same cycle no update", int'(weight), w0);
        ticks(10);
        pulse(1'b1, 1'b0);
        repeat (3) @(negedge clk);
        exp_w = model_down(w0, int'(w_floor));
        chk("R5 post timer restarted", int'(weight), exp_w);
        ticks(110);
        w0 = exp_w;
        pulse(1'b1, 1'b1);
        ticks(10);
        pulse(1'b0, 1'b1);
        repeat (3) @(negedge clk);
        exp_w = model_up(w0, int'(w_ceil));
        chk("R5 pre timer restarted", int'(weight), exp_w);
    endtask

    task automatic t_age();
        ticks(110);
        pulse(1'b1, 1'b0);
        ticks(300);
        pulse(1'b0, 1'b1);
        repeat (3) @(negedge clk);
        chk("R6 age saturates no wrap", int'(weight), exp_w);
        ticks(110);
        pulse(1'b1, 1'b0);
        repeat (50) @(negedge clk);
        pulse(1'b0, 1'b1);
        repeat (3) @(negedge clk);
        chk("R6 no tick no advance", int'(weight), exp_w);
        ticks(110);
        pulse(1'b1, 1'b0);
        ticks(20);
        @(negedge clk);
        tick = 1'b1;
        pre_spike = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        pre_spike = 1'b0;
        ticks(3);
        pulse(1'b0, 1'b1);
        repeat (3) @(negedge clk);
        exp_w = model_up(exp_w, int'(w_ceil));
        chk("R6 spike beats tick", int'(weight), exp_w);
    endtask

    task automatic t_bounds();
        do_reset(40, 1030);
        pair(1'b0, 10, "R7 clamp at ceiling");
        chk("R7 ceiling value", int'(weight), 1030);
        pair(1'b0, 10, "R7 hold at ceiling");
        do_reset(1020, 3000);
        pair(1'b1, 10, "R7 clamp at floor");
        chk("R7 floor value", int'(weight), 1020);
        pair(1'b1, 10, "R7 hold at floor");
    endtask

    task automatic t_small_step();
        int guard;
        int w0;
        do_reset(10, 3000);
        guard = 0;
        while (exp_w >= 64 && guard < 400) begin
            pair(1'b1, 5, "R3 descent");
            guard++;
        end
        w0 = exp_w;
        pair(1'b1, 5, "R9 one LSB down");
        chk("R9 step is one", int'(weight), w0 - 1);
        w0 = exp_w;
        pair(1'b0, 5, "R9 one LSB up");
        chk("R9 up step is one", int'(weight), w0 + 1);
    endtask

    initial begin
        t_reset();
        t_windows();
        t_same_cycle();
        t_age();
        t_bounds();
        t_small_step();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule